// File: doc/BRIEF.md
# ODT Power-Down Transition Window Tracker

This block sits on the controller side of a DDR3-class memory interface. It samples clock-enable, the on-die termination (ODT) control and the refresh command strobe once per clock. From them it works out the span of cycles around precharge power-down entry in which the termination may follow ODT either synchronously or asynchronously. Each ODT edge is tagged with one of three classes: synchronous (before the span), uncertain (inside it) or asynchronous (after it, while still powered down). The span only exists when the DLL is set to freeze in precharge power-down, which is mode register 0 bit A12 equal to 0. That bit is fed to the block on `dll_fast_exit`.

The span opens a few cycles before the clock-enable fall, so the tracker cannot decide in real time. Every ODT edge, the sampled clock-enable level and the span flag are reported a fixed lead of `WL-2` cycles after the edge was sampled. By then it is known whether power-down entry followed. The span normally closes at the end of the power-down entry delay. If a refresh is still running, it closes at the end of that refresh instead, whichever comes later. Write latency, entry delay and refresh time are configuration inputs counted in clock cycles, and they are meant to be held steady while traffic is tracked.

The event output is a plain one-cycle strobe carrying a class code. It has no ready signal and no back-pressure, because a bus monitor cannot stall the memory interface. Whatever consumes it must take each strobe in the cycle it appears.

Top module: `odtw_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `evt_valid`, `evt_class` and `win_active` to 0 and discards every ODT edge, clock-enable fall and refresh seen before it. No event is reported afterwards for activity that happened before the reset.
- R2: Every change of the sampled `odt` level, rising or falling, produces exactly one `evt_valid` pulse. An edge sampled at clock edge t is reported at clock edge t+WL-2, where WL is the clamped write latency.
- R3: The uncertain span starts at sampled cycle F-WL+2, where F is the first cycle in which `cke` is sampled low after being high. Cycle F-WL+1, which is where the WL-1 backward count begins, lies outside the span.
- R4: Without a refresh in progress, the span ends at cycle F+`pde_cycles`, and that cycle is included in the span.
- R5: If the latest refresh command at cycle R satisfies R <= F < R+`rfc_cycles`, the span ends at the later of R+`rfc_cycles` and F+`pde_cycles`, both included. A refresh that ended at or before F does not extend the span.
- R6: Class codes on `evt_class` are 2'b00 for synchronous, 2'b01 for uncertain and 2'b10 for asynchronous. An edge inside the span is 01. An edge after the span while `cke` is still low is 10. Every other edge is 00, including edges after power-down exit. Code 11 never appears.
- R7: `win_active` is high in exactly the cycles whose reported sampled cycle lies inside the span, so it has the same WL-2 lead as the events.
- R8: With `dll_fast_exit` = 1, every edge is reported with class 00 and `win_active` stays low.
- R9: `wl_cycles` values below 5 act as 5, and values above 12 act as 12.
- R10: A second refresh command restarts the refresh count from the newer command. Only the latest refresh decides the extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dll_fast_exit | input | 1 | Mode register 0 bit A12; 0 freezes the DLL in power-down and enables the span |
| wl_cycles | input | 4 | Write latency in cycles (5 to 12) |
| pde_cycles | input | 9 | Power-down entry delay in cycles |
| rfc_cycles | input | 9 | Refresh cycle time in cycles |
| cke | input | 1 | Sampled clock-enable |
| odt | input | 1 | Sampled ODT control |
| ref_cmd | input | 1 | High for one cycle on a refresh command |
| evt_valid | output | 1 | One-cycle strobe for a classified ODT edge |
| evt_class | output | 2 | Class of the reported edge: 00 sync, 01 uncertain, 10 async |
| win_active | output | 1 | High while the reported cycle lies inside the span |

## Verification
The embedded properties watch, on every cycle, that a legal class code is produced, that the span flag only rises after a clock-enable fall, that no asynchronous edge is reported while the span is open, that a refresh count that has run out stays idle, and that the fast-exit DLL setting suppresses both the span and non-synchronous classes. The exact placement of the span's first and last cycles, the extension by a running refresh, the choice of the newer of two refreshes, the write-latency clamp and the reporting latency are all set by counts of many cycles. Only the bench's scenarios can show these, because they compare each event and each cycle of the span flag against cycle numbers worked out from the rules above.

// File: rtl/odtw_pkg.sv
package odtw_pkg;

  typedef enum logic [1:0] {
    ODT_SYNC   = 2'b00,
    ODT_UNSURE = 2'b01,
    ODT_ASYNC  = 2'b10
  } odt_class_e;

endpackage

// File: rtl/odtw_delay_line.sv
module odtw_delay_line #(
  parameter int              WIDTH   = 2,
  parameter int              DEPTH   = 10,
  parameter int              SEL_W   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] tap
);

  logic [WIDTH-1:0] stg [DEPTH];

  // stage k holds the input sampled k+1 edges ago
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  // tap select; out-of-range picks the oldest stage
  always_comb begin
    tap = stg[DEPTH-1];
    for (int i = 0; i < DEPTH; i++) begin
      if (sel == SEL_W'(i)) tap = stg[i];
    end
  end

endmodule

// File: rtl/odtw_refresh_track.sv
module odtw_refresh_track #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_cmd,
  input  logic [CNT_W-1:0] rfc_cycles,
  output logic [CNT_W-1:0] rem_now
);

  // cycles of the latest refresh still outstanding after this edge
  logic [CNT_W-1:0] left_q;

  always_comb begin
    if (ref_cmd)             rem_now = rfc_cycles;
    else if (left_q != '0)   rem_now = left_q - CNT_W'(1);
    else                     rem_now = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                 left_q <= '0;
    else if (ref_cmd)        left_q <= rfc_cycles;    // newer refresh wins (R10)
    else if (left_q != '0)   left_q <= left_q - CNT_W'(1);
  end

  p_rfc_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!ref_cmd && left_q == '0) |=> (left_q == '0))
    else $error("refresh count restarted without a command");

endmodule

// File: rtl/odtw_window_ctrl.sv
module odtw_window_ctrl #(
  parameter int CNT_W  = 9,
  parameter int LEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_pd,
  input  logic [LEAD_W-1:0] lead,
  input  logic [CNT_W-1:0]  pde_cycles,
  input  logic [CNT_W-1:0]  ref_rem,
  output logic              in_win
);

  localparam int SPAN_W = CNT_W + 1;

  logic [SPAN_W-1:0] cnt_q;
  logic [SPAN_W-1:0] cnt_dec;
  logic [CNT_W-1:0]  tail;
  logic [SPAN_W-1:0] span;

  // span end: entry delay or remaining refresh, whichever is later (R4, R5)
  assign tail    = (ref_rem > pde_cycles) ? ref_rem : pde_cycles;
  assign span    = SPAN_W'(lead) + SPAN_W'(tail);
  assign cnt_dec = (cnt_q != '0) ? cnt_q - SPAN_W'(1) : '0;
  assign in_win  = fall_pd || (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (fall_pd && span > cnt_dec) cnt_q <= span;
    else                             cnt_q <= cnt_dec;
  end

  p_span_cover_r4: assert property (@(posedge clk) disable iff (rst)
    fall_pd |=> in_win)
    else $error("span closed right after power-down entry");

endmodule

// File: rtl/odtw_tracker.sv
module odtw_tracker
  import odtw_pkg::*;
#(
  parameter int WL_W   = 4,
  parameter int CNT_W  = 9,
  parameter int WL_MIN = 5,
  parameter int WL_MAX = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dll_fast_exit,
  input  logic [WL_W-1:0]  wl_cycles,
  input  logic [CNT_W-1:0] pde_cycles,
  input  logic [CNT_W-1:0] rfc_cycles,
  input  logic             cke,
  input  logic             odt,
  input  logic             ref_cmd,
  output logic             evt_valid,
  output logic [1:0]       evt_class,
  output logic             win_active
);

  localparam int MAX_LEAD = WL_MAX - 2;
  localparam int LEAD_W   = $clog2(MAX_LEAD + 1);
  localparam int SEL_W    = $clog2(MAX_LEAD);
  localparam logic [WL_W-1:0] WL_LO = WL_W'(WL_MIN);
  localparam logic [WL_W-1:0] WL_HI = WL_W'(WL_MAX);

  // write-latency clamp (R9) and reporting lead WL-2
  logic [WL_W-1:0]   wl_eff;
  logic [LEAD_W-1:0] lead;
  logic [SEL_W-1:0]  tap_sel;

  assign wl_eff  = (wl_cycles < WL_LO) ? WL_LO :
                   (wl_cycles > WL_HI) ? WL_HI : wl_cycles;
  assign lead    = LEAD_W'(wl_eff - WL_W'(2));
  assign tap_sel = SEL_W'(lead - LEAD_W'(1));

  // input sampling and edge detection
  logic cke_q, odt_q;
  logic cke_fall, odt_edge, fall_pd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q <= 1'b1;
      odt_q <= 1'b0;
    end else begin
      cke_q <= cke;
      odt_q <= odt;
    end
  end

  assign cke_fall = cke_q & ~cke;
  assign odt_edge = odt ^ odt_q;
  assign fall_pd  = cke_fall & ~dll_fast_exit;

  // delayed edge and clock-enable stream
  logic [1:0] line_tap;
  logic       cke_t, edge_t;

  odtw_delay_line #(
    .WIDTH  (2),
    .DEPTH  (MAX_LEAD),
    .SEL_W  (SEL_W),
    .RST_VAL(2'b10)
  ) u_line (
    .clk (clk),
    .rst (rst),
    .din ({cke, odt_edge}),
    .sel (tap_sel),
    .tap (line_tap)
  );

  assign cke_t  = line_tap[1];
  assign edge_t = line_tap[0];

  // refresh tracking and span counter
  logic [CNT_W-1:0] ref_rem;
  logic             in_win;

  odtw_refresh_track #(.CNT_W(CNT_W)) u_ref (
    .clk        (clk),
    .rst        (rst),
    .ref_cmd    (ref_cmd),
    .rfc_cycles (rfc_cycles),
    .rem_now    (ref_rem)
  );

  odtw_window_ctrl #(.CNT_W(CNT_W), .LEAD_W(LEAD_W)) u_win (
    .clk        (clk),
    .rst        (rst),
    .fall_pd    (fall_pd),
    .lead       (lead),
    .pde_cycles (pde_cycles),
    .ref_rem    (ref_rem),
    .in_win     (in_win)
  );

  // classification of the delayed edge (R6, R8)
  odt_class_e cls_next;

  always_comb begin
    if (dll_fast_exit)  cls_next = ODT_SYNC;
    else if (in_win)    cls_next = ODT_UNSURE;
    else if (!cke_t)    cls_next = ODT_ASYNC;
    else                cls_next = ODT_SYNC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid  <= 1'b0;
      evt_class  <= 2'b00;
      win_active <= 1'b0;
    end else begin
      evt_valid  <= edge_t;
      evt_class  <= edge_t ? cls_next : ODT_SYNC;
      win_active <= in_win & ~dll_fast_exit;
    end
  end

  p_class_legal_r6: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt_class != 2'b11))
    else $error("illegal class code");

  p_async_outside_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_class == ODT_ASYNC) |-> !win_active)
    else $error("async edge reported inside span");

  p_win_start_fall_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(win_active) && !$past(dll_fast_exit, 2)) |-> $past(cke_fall))
    else $error("span opened without clock-enable fall");

  p_a12_nowin_r8: assert property (@(posedge clk) disable iff (rst)
    $past(dll_fast_exit) |-> !win_active)
    else $error("span flagged with fast-exit DLL");

  p_a12_sync_r8: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && $past(dll_fast_exit)) |-> (evt_class == ODT_SYNC))
    else $error("non-sync class with fast-exit DLL");

endmodule

// File: tb/tb_odtw_tracker.sv
`timescale 1ns/1ps
module tb_odtw_tracker;

  logic       clk = 1'b0;
  logic       rst;
  logic       dll_fast_exit;
  logic [3:0] wl_cycles;
  logic [8:0] pde_cycles, rfc_cycles;
  logic       cke, odt, ref_cmd;
  logic       evt_valid;
  logic [1:0] evt_class;
  logic       win_active;

  always #4 clk = ~clk;   // 125 MHz

  odtw_tracker dut (
    .clk(clk), .rst(rst), .dll_fast_exit(dll_fast_exit),
    .wl_cycles(wl_cycles), .pde_cycles(pde_cycles), .rfc_cycles(rfc_cycles),
    .cke(cke), .odt(odt), .ref_cmd(ref_cmd),
    .evt_valid(evt_valid), .evt_class(evt_class), .win_active(win_active)
  );

  int  cyc = 0;
  int  vectors = 0;
  int  fails = 0;
  bit  exp_win [0:16383];
  int         q_at  [$];
  logic [1:0] q_cls [$];
  string      q_req [$];
  logic odt_lvl = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: span flag every cycle (R7) and scoreboard pops (R2)
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (win_active !== exp_win[cyc]) begin
        fails++;
        $display("FAIL R7 cycle %0d win_active actual %0b expected %0b", cyc, win_active, exp_win[cyc]);
      end
      while (q_at.size() > 0 && q_at[0] < cyc) begin
        fails++;
        $display("FAIL %s/R2 missed event: actual none, expected at cycle %0d", q_req[0], q_at[0]);
        void'(q_at.pop_front()); void'(q_cls.pop_front()); void'(q_req.pop_front());
      end
      if (evt_valid) begin
        vectors++;
        if (q_at.size() == 0) begin
          fails++;
          $display("FAIL R2 cycle %0d: actual event class %0b, expected none", cyc, evt_class);
        end else begin
          if (q_at[0] != cyc || evt_class !== q_cls[0]) begin
            fails++;
            $display("FAIL %s cycle/class actual %0d/%0b expected %0d/%0b",
                     q_req[0], cyc, evt_class, q_at[0], q_cls[0]);
          end
          void'(q_at.pop_front()); void'(q_cls.pop_front()); void'(q_req.pop_front());
        end
      end
    end
  end

  // driver: computes expectations from the requirements, then drives
  task automatic run_scen(input string req, input int wl_in, input int pde, input int rfc,
                          input bit a12, input int fk, input int xk,
                          input int r1, input int r2, input int tg [8]);
    int  wle, n, base, endc, lr, at;
    bit  cke_p [0:127];
    bit  odt_p [0:127];
    bit  ref_p [0:127];
    bit  prev, inw;
    logic [1:0] cls;
    wle  = (wl_in < 5) ? 5 : (wl_in > 12) ? 12 : wl_in;     // R9
    n    = xk + wle + 8;
    base = cyc + 1;
    for (int k = 0; k < 128; k++) begin
      cke_p[k] = !(k >= fk && k < xk);
      ref_p[k] = (k == r1) || (k == r2);
    end
    prev = odt_lvl;
    for (int k = 0; k < 128; k++) begin
      for (int j = 0; j < 8; j++) if (tg[j] == k) prev = ~prev;
      odt_p[k] = prev;
    end
    endc = fk + pde;                                           // R4
    lr = -1;
    if (r1 >= 0 && r1 <= fk) lr = r1;
    if (r2 >= 0 && r2 <= fk && r2 > lr) lr = r2;               // R10
    if (lr >= 0 && fk < lr + rfc && lr + rfc > endc) endc = lr + rfc;  // R5
    for (int k = 0; k < n; k++) begin
      inw = !a12 && k >= fk - wle + 2 && k <= endc;            // R3
      if (inw) exp_win[base + k + wle - 2] = 1'b1;
      prev = (k == 0) ? odt_lvl : odt_p[k-1];
      if (odt_p[k] != prev) begin
        if (a12)           cls = 2'b00;                        // R8
        else if (inw)      cls = 2'b01;                        // R6
        else if (!cke_p[k]) cls = 2'b10;
        else               cls = 2'b00;
        at = base + k + wle - 2;
        q_at.push_back(at); q_cls.push_back(cls); q_req.push_back(req);
      end
    end
    wl_cycles = 4'(wl_in); pde_cycles = 9'(pde); rfc_cycles = 9'(rfc);
    dll_fast_exit = a12;
    for (int k = 0; k < n; k++) begin
      cke = cke_p[k]; odt = odt_p[k]; ref_cmd = ref_p[k];
      @(negedge clk);
    end
    odt_lvl = odt_p[n-1];
    ref_cmd = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cke = 1'b1; odt = 1'b0; ref_cmd = 1'b0;
    dll_fast_exit = 1'b0; wl_cycles = 4'd6; pde_cycles = 9'd4; rfc_cycles = 9'd10;
    repeat (3) @(negedge clk);
    vectors++;
    if (evt_valid !== 1'b0 || evt_class !== 2'b00 || win_active !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %0b%0b%0b expected 000", evt_valid, evt_class, win_active);
    end
    rst = 1'b0;
    // R1: activity killed by a reset produces nothing afterwards
    odt = 1'b1; cke = 1'b0; ref_cmd = 1'b1;
    @(negedge clk);
    rst = 1'b1; odt = 1'b0; cke = 1'b1; ref_cmd = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (15) @(negedge clk);

    run_scen("R3,R4,R6", 6, 4, 10, 1'b0, 20, 40, -1, -1, '{15,16,24,25,30,42,-1,-1});
    run_scen("R5",       8, 5, 20, 1'b0, 15, 45, 10, -1, '{8,9,30,31,-1,-1,-1,-1});
    run_scen("R10",      5, 3, 12, 1'b0, 14, 35, 5, 12,  '{10,11,18,24,25,-1,-1,-1});
    run_scen("R5",       7, 6, 8,  1'b0, 10, 30, 2, -1,  '{4,5,16,17,-1,-1,-1,-1});
    run_scen("R8",       6, 4, 10, 1'b1, 20, 40, -1, -1, '{15,16,24,25,30,42,-1,-1});
    run_scen("R9",       15, 2, 10, 1'b0, 30, 40, -1, -1, '{19,20,32,33,-1,-1,-1,-1});
    run_scen("R9",       3, 2, 10, 1'b0, 20, 30, -1, -1, '{16,17,22,23,-1,-1,-1,-1});

    repeat (5) @(negedge clk);
    if (q_at.size() != 0) begin
      fails++;
      $display("FAIL R2 pending events actual %0d expected 0", q_at.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL R2 watchdog: actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule